// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects interrupt requests from a parameterized set of sources and decides, once per cycle, whether the processor should be interrupted. Each source has a pending flag, an enable bit and a 3-bit priority. When the highest-priority request that is both pending and enabled ranks strictly above the processor's current priority level, the block issues a one-cycle take pulse. With that pulse it reports the winning source index, its priority and the vector address. It also raises the processor level to that priority, so that requests at the same or lower levels stay masked until software lowers the level again.

Vector addresses come from one of two tables with the same layout. A single select input switches every vector to the alternate base. The three lowest source indices can also be set by external pins. Each pin passes through a synchronizer and an edge detector whose polarity is chosen per pin. A wake output accompanies the take pulse while the processor reports that it is sleeping or idle. Software clears flags through a write-one-to-clear port and rewrites the level through a simple write port.

Top module: `vic_ctrl`

## Requirements
- R1: A high `src_req` bit sets its flag at the next clock edge. The flag stays set until a high `src_clr` bit clears it. When set and clear arrive in the same cycle, the set wins. `flags_o` shows the registered flags.
- R2: A pending flag can only be taken while its `src_en` bit is high. A pending source that is disabled never produces a take.
- R3: A take occurs only when the winning priority is strictly greater than `cur_lvl_o`. A priority equal to the level, or priority 0, is never taken. `take_o` rises one clock after the flag is visible on `flags_o`.
- R4: On a take, `cur_lvl_o` becomes the taken priority in the same cycle that `take_o` is high. As a result, no source with that priority or a lower one is taken afterwards.
- R5: Among eligible sources, the highest priority wins. When several sources share that priority, the lowest index wins. `irq_idx_o` and `irq_prio_o` report the winner and hold their value between takes.
- R6: `irq_vec_o` equals the table base plus two times the winning index. The base is `ALT_BASE` when `alt_tbl` was high at the deciding edge, and `DEF_BASE` otherwise.
- R7: External pin k (k < 3) sets flag k. When `ext_rise[k]` is 1 the pin sets the flag on a rising edge, and when it is 0 on a falling edge. The opposite edge has no effect. The flag appears on `flags_o` three clocks after the pin changes.
- R8: `wake_o` is high exactly in the cycles where `take_o` is high and `sleeping` was high at the deciding edge.
- R9: `lvl_we` loads `lvl_wdata` into the level at the next edge. Flags that are still set and rank above the new level are then taken again. When a take and a level write occur in the same cycle, the take sets the level.
- R10: After reset, the flags, the level, `take_o`, `wake_o`, `irq_idx_o`, `irq_prio_o` and `irq_vec_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_req | input | N | Per-source request pulses that set flags |
| src_clr | input | N | Write-one-to-clear for flags |
| src_en | input | N | Per-source enable |
| src_prio | input | 3*N | Per-source priority, source i in bits [3i+2:3i] |
| ext_pin | input | 3 | External request pins, feeding sources 0 to 2 |
| ext_rise | input | 3 | Edge select per pin: 1 rising, 0 falling |
| alt_tbl | input | 1 | Select the alternate vector table |
| lvl_we | input | 1 | Level write strobe |
| lvl_wdata | input | 3 | New processor level |
| sleeping | input | 1 | Processor is in sleep or idle |
| take_o | output | 1 | One-cycle interrupt take pulse |
| irq_idx_o | output | $clog2(N) | Index of the taken source |
| irq_prio_o | output | 3 | Priority of the taken source |
| irq_vec_o | output | AW | Vector address of the taken source |
| wake_o | output | 1 | Wake request, high together with the take |
| cur_lvl_o | output | 3 | Current processor priority level |
| flags_o | output | N | Pending request flags |

## Verification
A corrupted level register shows up as a take against a level it should have masked, or as a request that is never taken. Either fault appears on `take_o` one clock after the faulty value exists, and on `cur_lvl_o` at once. A wrong flag shows on `flags_o` at the next edge. A wrong arbitration or base choice shows in the same cycle as the take, on `irq_idx_o` and `irq_vec_o`. A fault in the external synchronizer shifts or removes the flag set three clocks after the pin changes. The bench therefore compares every output against a cycle-level model on every clock.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int PRIO_W = 3;
    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/vic_edge_det.sv
module vic_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    output logic pulse
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin};
        st_d.prev = st_q.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // a change of rise_sel alone creates no pulse: only the pin history matters
    assign pulse = rise_sel ? ( st_q.sync[SYNC_STAGES-1] & ~st_q.prev)
                            : (~st_q.sync[SYNC_STAGES-1] &  st_q.prev);
endmodule

// File: rtl/vic_arbiter.sv
module vic_arbiter
    import vic_pkg::*;
#(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]        pend,
    input  logic [N-1:0]        en,
    input  logic [N*PRIO_W-1:0] prio_flat,
    output logic                found,
    output logic [IW-1:0]       win_idx,
    output prio_t               win_prio
);
    prio_t cand;

    // ascending scan with strict compare: the first index at the top priority stays
    always_comb begin
        found    = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        cand     = '0;
        for (int i = 0; i < N; i++) begin
            cand = prio_flat[i*PRIO_W +: PRIO_W];
            if (pend[i] && en[i] && (cand > win_prio)) begin
                found    = 1'b1;
                win_idx  = IW'(i);
                win_prio = cand;
            end
        end
    end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
    import vic_pkg::*;
#(
    parameter int              N        = 16,
    parameter int              EXT_N    = 3,
    parameter int              AW       = 16,
    parameter logic [AW-1:0]   DEF_BASE = 16'h0004,
    parameter logic [AW-1:0]   ALT_BASE = 16'h0104,
    parameter int              IW       = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        src_req,
    input  logic [N-1:0]        src_clr,
    input  logic [N-1:0]        src_en,
    input  logic [N*PRIO_W-1:0] src_prio,
    input  logic [EXT_N-1:0]    ext_pin,
    input  logic [EXT_N-1:0]    ext_rise,
    input  logic                alt_tbl,
    input  logic                lvl_we,
    input  logic [PRIO_W-1:0]   lvl_wdata,
    input  logic                sleeping,
    output logic                take_o,
    output logic [IW-1:0]       irq_idx_o,
    output logic [PRIO_W-1:0]   irq_prio_o,
    output logic [AW-1:0]       irq_vec_o,
    output logic                wake_o,
    output logic [PRIO_W-1:0]   cur_lvl_o,
    output logic [N-1:0]        flags_o
);
    typedef struct packed {
        logic [N-1:0]  flags;
        prio_t         lvl;
        logic          take;
        logic [IW-1:0] idx;
        prio_t         prio;
        logic [AW-1:0] vec;
        logic          wake;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    logic [N-1:0]  ext_set;
    logic          found;
    logic [IW-1:0] win_idx;
    prio_t         win_prio;
    logic [AW-1:0] tbl_base;

    for (genvar g = 0; g < N; g++) begin : g_ext
        if (g < EXT_N) begin : g_pin
            vic_edge_det #(.SYNC_STAGES(2)) u_edge (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin      (ext_pin[g]),
                .rise_sel (ext_rise[g]),
                .pulse    (ext_set[g])
            );
        end else begin : g_none
            assign ext_set[g] = 1'b0;
        end
    end

    vic_arbiter #(.N(N), .IW(IW)) u_arb (
        .pend      (st_q.flags),
        .en        (src_en),
        .prio_flat (src_prio),
        .found     (found),
        .win_idx   (win_idx),
        .win_prio  (win_prio)
    );

    assign tbl_base = alt_tbl ? ALT_BASE : DEF_BASE;

    always_comb begin
        st_d       = st_q;
        st_d.take  = 1'b0;
        st_d.wake  = 1'b0;
        // a new request beats a clear in the same cycle
        st_d.flags = (st_q.flags & ~src_clr) | src_req | ext_set;
        if (lvl_we) st_d.lvl = lvl_wdata;
        if (found && (win_prio > st_q.lvl)) begin
            st_d.take = 1'b1;
            st_d.idx  = win_idx;
            st_d.prio = win_prio;
            st_d.vec  = tbl_base + (AW'(win_idx) << 1);
            st_d.lvl  = win_prio;
            st_d.wake = sleeping;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take_o     = st_q.take;
    assign irq_idx_o  = st_q.idx;
    assign irq_prio_o = st_q.prio;
    assign irq_vec_o  = st_q.vec;
    assign wake_o     = st_q.wake;
    assign cur_lvl_o  = st_q.lvl;
    assign flags_o    = st_q.flags;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
    parameter int            N        = 16,
    parameter int            AW       = 16,
    parameter logic [AW-1:0] DEF_BASE = 16'h0004,
    parameter logic [AW-1:0] ALT_BASE = 16'h0104,
    parameter int            IW       = $clog2(N)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  src_en,
    input logic          alt_tbl,
    input logic          lvl_we,
    input logic          take_o,
    input logic [IW-1:0] irq_idx_o,
    input logic [2:0]    irq_prio_o,
    input logic [AW-1:0] irq_vec_o,
    input logic          wake_o,
    input logic [2:0]    cur_lvl_o,
    input logic [N-1:0]  flags_o
);
    logic [N-1:0] elig_prev;
    always_ff @(posedge clk) elig_prev <= src_en & flags_o;

    a_r3_strictly_above: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (irq_prio_o > $past(cur_lvl_o)));

    a_r4_level_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (cur_lvl_o == irq_prio_o));

    a_r2_pending_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> elig_prev[irq_idx_o]);

    a_r6_vector_base: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (irq_vec_o == (($past(alt_tbl) ? ALT_BASE : DEF_BASE) + (AW'(irq_idx_o) << 1))));

    a_r8_wake_with_take: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> take_o);

    a_r9_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && !$past(lvl_we)) |-> $stable(cur_lvl_o));
endmodule

bind vic_ctrl vic_ctrl_chk #(
    .N(N), .AW(AW), .DEF_BASE(DEF_BASE), .ALT_BASE(ALT_BASE), .IW(IW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_en     (src_en),
    .alt_tbl    (alt_tbl),
    .lvl_we     (lvl_we),
    .take_o     (take_o),
    .irq_idx_o  (irq_idx_o),
    .irq_prio_o (irq_prio_o),
    .irq_vec_o  (irq_vec_o),
    .wake_o     (wake_o),
    .cur_lvl_o  (cur_lvl_o),
    .flags_o    (flags_o)
);

// File: tb/vic_ctrl_test.sv
module vic_ctrl_test;
    localparam int            N   = 16;
    localparam int            IW  = 4;
    localparam int            AW  = 16;
    localparam int            NX  = 3;
    localparam logic [AW-1:0] DEF = 16'h0004;
    localparam logic [AW-1:0] ALT = 16'h0104;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    src_req = '0, src_clr = '0, src_en = '0;
    logic [N*3-1:0]  src_prio = '0;
    logic [NX-1:0]   ext_pin = '0, ext_rise = '0;
    logic            alt_tbl = 1'b0, lvl_we = 1'b0, sleeping = 1'b0;
    logic [2:0]      lvl_wdata = '0;
    logic            take_o, wake_o;
    logic [IW-1:0]   irq_idx_o;
    logic [2:0]      irq_prio_o, cur_lvl_o;
    logic [AW-1:0]   irq_vec_o;
    logic [N-1:0]    flags_o;

    vic_ctrl uut (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_clr(src_clr),
        .src_en(src_en), .src_prio(src_prio), .ext_pin(ext_pin), .ext_rise(ext_rise),
        .alt_tbl(alt_tbl), .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .sleeping(sleeping),
        .take_o(take_o), .irq_idx_o(irq_idx_o), .irq_prio_o(irq_prio_o),
        .irq_vec_o(irq_vec_o), .wake_o(wake_o), .cur_lvl_o(cur_lvl_o), .flags_o(flags_o)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [N-1:0]  m_flags = '0;
    logic [2:0]    m_lvl = '0, m_prio = '0;
    logic          m_take = 1'b0, m_wake = 1'b0;
    logic [IW-1:0] m_idx = '0;
    logic [AW-1:0] m_vec = '0;
    logic [NX-1:0] m_s0 = '0, m_s1 = '0, m_prev = '0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] exp_vec(input logic alt, input int idx);
        return (alt ? ALT : DEF) + AW'(idx * 2);
    endfunction

    task automatic model_step();
        logic [N-1:0] set_v;
        logic [2:0]   bp;
        int           bi;
        logic         fnd;
        set_v = src_req;
        for (int e = 0; e < NX; e++) begin
            if (ext_rise[e]) set_v[e] = set_v[e] | (m_s1[e] & ~m_prev[e]);
            else             set_v[e] = set_v[e] | (~m_s1[e] & m_prev[e]);
        end
        // descending scan, ties move toward the lower index
        fnd = 1'b0; bp = '0; bi = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_flags[i] && src_en[i] && src_prio[i*3 +: 3] != 3'd0 &&
                src_prio[i*3 +: 3] >= bp) begin
                fnd = 1'b1; bp = src_prio[i*3 +: 3]; bi = i;
            end
        end
        m_flags = (m_flags & ~src_clr) | set_v;
        m_take = 1'b0; m_wake = 1'b0;
        if (fnd && bp > m_lvl) begin
            m_take = 1'b1; m_idx = IW'(bi); m_prio = bp;
            m_vec = exp_vec(alt_tbl, bi); m_wake = sleeping; m_lvl = bp;
        end else if (lvl_we) begin
            m_lvl = lvl_wdata;
        end
        m_prev = m_s1; m_s1 = m_s0; m_s0 = ext_pin;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        model_step();
        chk("R3 take_o", take_o, m_take);
        chk("R4 cur_lvl_o", cur_lvl_o, m_lvl);
        chk("R5 irq_idx_o", irq_idx_o, m_idx);
        chk("R5 irq_prio_o", irq_prio_o, m_prio);
        chk("R6 irq_vec_o", irq_vec_o, m_vec);
        chk("R8 wake_o", wake_o, m_wake);
        chk("R1 flags_o", flags_o, m_flags);
    endtask

    task automatic set_prio(input int i, input logic [2:0] p);
        src_prio[i*3 +: 3] = p;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1;
        chk("R10 take_o reset", take_o, 0);
        chk("R10 cur_lvl_o reset", cur_lvl_o, 0);
        chk("R10 flags_o reset", flags_o, 0);
        chk("R10 irq_vec_o reset", irq_vec_o, 0);
        chk("R10 wake_o reset", wake_o, 0);
        rst_n = 1'b1;

        // R1 and R2: flag set, disabled source ignored, then enabled
        set_prio(5, 3'd4);
        src_req = N'(1 << 5);
        tick(); src_req = '0;
        chk("R1 flag set", flags_o[5], 1);
        chk("R3 no take same edge", take_o, 0);
        tick();
        chk("R2 disabled not taken", take_o, 0);
        src_en[5] = 1'b1;
        tick();
        chk("R2 enabled taken", take_o, 1);
        chk("R5 idx", irq_idx_o, 5);
        chk("R6 default vec", irq_vec_o, DEF + 16'd10);
        chk("R4 level loaded", cur_lvl_o, 4);
        tick();
        chk("R4 equal masked", take_o, 0);
        src_req = N'(1 << 5); src_clr = N'(1 << 5);
        tick();
        chk("R1 set beats clear", flags_o[5], 1);
        src_req = '0;
        tick(); src_clr = '0;
        chk("R1 cleared", flags_o[5], 0);

        // R5 tie, R3 equal, R9 rewrite and retrigger
        set_prio(3, 3'd6); set_prio(9, 3'd6); set_prio(1, 3'd5);
        src_en[3] = 1'b1; src_en[9] = 1'b1; src_en[1] = 1'b1;
        src_req = N'((1 << 1) | (1 << 3) | (1 << 9));
        tick(); src_req = '0;
        tick();
        chk("R5 tie lowest index", irq_idx_o, 3);
        chk("R5 take on tie", take_o, 1);
        tick();
        chk("R3 equal level not taken", take_o, 0);
        lvl_we = 1'b1; lvl_wdata = 3'd5;
        tick(); lvl_we = 1'b0;
        chk("R9 level written", cur_lvl_o, 5);
        tick();
        chk("R9 retrigger", take_o, 1);
        chk("R9 retrigger idx", irq_idx_o, 3);
        src_clr = N'(1 << 3);
        tick(); src_clr = '0;
        lvl_we = 1'b1; lvl_wdata = 3'd0;
        tick();
        lvl_wdata = 3'd2;
        tick(); lvl_we = 1'b0;
        chk("R9 take beats write", take_o, 1);
        chk("R9 take beats write lvl", cur_lvl_o, 6);
        chk("R9 take beats write idx", irq_idx_o, 9);

        // R6 alternate table, R8 wake
        src_clr = N'(1 << 9); alt_tbl = 1'b1; sleeping = 1'b1;
        lvl_we = 1'b1; lvl_wdata = 3'd0;
        tick(); src_clr = '0; lvl_we = 1'b0;
        tick();
        chk("R6 alt take", take_o, 1);
        chk("R6 alt vec", irq_vec_o, ALT + 16'd2);
        chk("R8 wake with take", wake_o, 1);
        tick();
        chk("R8 wake only with take", wake_o, 0);
        alt_tbl = 1'b0; sleeping = 1'b0;

        // R3 priority zero never taken
        src_clr = N'(1 << 1); lvl_we = 1'b1; lvl_wdata = 3'd0;
        tick(); src_clr = '0; lvl_we = 1'b0;
        src_en[7] = 1'b1; src_req = N'(1 << 7);
        tick(); src_req = '0;
        tick(); tick();
        chk("R3 prio zero pending", flags_o[7], 1);
        chk("R3 prio zero not taken", take_o, 0);
        src_clr = N'(1 << 7);
        tick(); src_clr = '0;

        // R7 rising edge on pin 0
        set_prio(0, 3'd7); src_en[0] = 1'b1; ext_rise = 3'b001;
        ext_pin[0] = 1'b1;
        tick(); tick();
        chk("R7 rise not yet", flags_o[0], 0);
        tick();
        chk("R7 rise sets flag", flags_o[0], 1);
        tick();
        chk("R7 ext take", take_o, 1);
        chk("R7 ext idx", irq_idx_o, 0);
        src_clr = N'(1); lvl_we = 1'b1; lvl_wdata = 3'd0;
        tick(); src_clr = '0; lvl_we = 1'b0;

        // R7 falling edge select on pin 1
        ext_pin[1] = 1'b1;
        repeat (4) tick();
        chk("R7 opposite edge ignored", flags_o[1], 0);
        ext_pin[1] = 1'b0;
        tick(); tick();
        chk("R7 fall not yet", flags_o[1], 0);
        tick();
        chk("R7 fall sets flag", flags_o[1], 1);
        tick();
        src_clr = N'(1 << 1); lvl_we = 1'b1; lvl_wdata = 3'd0;
        tick(); src_clr = '0; lvl_we = 1'b0;

        // random phase, lockstep against the model
        for (int c = 0; c < 4000; c++) begin
            if (c % 500 == 0) src_prio = {$urandom, $urandom};
            if (c % 200 == 0) src_en = N'($urandom);
            if (c % 300 == 0) ext_rise = NX'($urandom);
            src_req  = N'($urandom & $urandom & $urandom & $urandom);
            src_clr  = ($urandom_range(3) == 0) ? N'($urandom) : '0;
            lvl_we   = ($urandom_range(5) == 0);
            lvl_wdata = 3'($urandom);
            alt_tbl  = 1'($urandom);
            sleeping = 1'($urandom);
            if ($urandom_range(3) == 0) ext_pin = ext_pin ^ NX'($urandom);
            tick();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule